// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare Flag

This block is a 32-bit timer that sits on a simple word-addressed register bus. A down-counter advances once per prescaled tick. The tick comes from one of three tick-enable inputs, or from none, and a 12-bit divider sets how many selected ticks make one count. When the counter is at zero, the next count either reloads it from the load register or wraps it to all ones, depending on the mode. When a count brings the counter to the compare value, a sticky flag is set. The interrupt line shows that flag, gated by two control bits.

Software controls the block through five word registers:

| Offset | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | load |
| 3 | compare |
| 4 | counter (read only) |

Extra control features:
- An overwrite option lets a load-register write land in the counter at once.
- An init-on-enable option preloads the counter when the timer is switched on.
- A soft reset clears most of the block but keeps the enable and power-mode bits.

All tick inputs are single-cycle enables in the one clock domain of the block. Reads return data in the same cycle as the access. Writes take effect at the next clock edge.

Top module: `tdt_top`

## Requirements
- R1: Offset 0 is control, 1 is status, 2 is load, 3 is compare and 4 is the counter. Writes to offsets 4 to 7 change nothing, and reads of offsets 5 to 7 return zero.
- R2: Control keeps bits [25:0] of a write. Bits [31:26] read as zero. Bit 16 (soft reset) always reads as zero.
- R3: After reset the registers read as follows, and irq is low:

| Register | Value after reset |
|---|---|
| control | 0 |
| status | 0 |
| load | 0xFFFFFFFF |
| compare | 0 |
| counter | 0 |

- R4: Control bits [25:24] pick the tick source:

| Bits [25:24] | Tick source |
|---|---|
| 00 | none (counter frozen) |
| 01 | tickMain |
| 10 | tickFast |
| 11 | tickSlow |

  Ticks on the inputs that are not selected are ignored.
- R5: With control bits [15:4] = N, the counter moves once per N+1 selected ticks.
- R6: On a prescaled tick, a non-zero counter decrements by one. A zero counter reloads from the load register when control bit 3 (reload mode) is 1, and becomes 0xFFFFFFFF when bit 3 is 0.
- R7: A control write that takes bit 0 (enable) from 0 to 1 while writing bit 1 (enable-mode) as 1 sets the counter as follows:
  - to the load register if bit 3 is written as 1;
  - to 0xFFFFFFFF if bit 3 is written as 0.

  If bit 1 is written as 0, the counter keeps its value.
- R8: A load-register write with control bit 17 (overwrite) set copies the value into the counter at once. Without bit 17 the counter is unchanged, and the new load value is first used at the next reload.
- R9: The status flag (status bit 0) is set by a prescaled tick that makes the counter equal to the compare register. It stays set until it is cleared. If a set and a clear happen in the same cycle, the set wins.
- R10: A status write with bit 0 = 1 clears the flag. A status write with bit 0 = 0 has no effect.
- R11: irq is high exactly when all three of these are 1: the flag, control bit 2 (compare interrupt enable) and control bit 0.
- R12: A control write with bit 16 = 1 is a soft reset:
  - control keeps only the written bits 0, 1, 18, 19, 20 and 21;
  - status, load, compare and counter return to their R3 values.
- R13: While control bit 0 is 0, ticks do not move the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read access, zero otherwise |
| tickMain | input | 1 | Main tick enable |
| tickFast | input | 1 | High-rate tick enable |
| tickSlow | input | 1 | Slow tick enable |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume a single bus access per cycle. They also assume tick inputs that change only between clock edges. The flag-clear property further assumes that no prescaled tick fires in the clear cycle; it excludes that cycle itself, because R9 lets a set win there. The stimulus drives ticks as isolated one-cycle pulses, one per call, with the bus idle. The one case where a status write and a compare hit coincide is placed on purpose, to exercise the set-wins rule.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int CNT_W  = 32;
  localparam int CTRL_W = 26;
  localparam int PSC_W  = 12;
  localparam int SRC_W  = 2;

  localparam int B_EN     = 0;
  localparam int B_INITEN = 1;
  localparam int B_OCIE   = 2;
  localparam int B_RLD    = 3;
  localparam int B_PSC    = 4;
  localparam int B_SWR    = 16;
  localparam int B_OVW    = 17;
  localparam int B_SRC    = 24;

  // bits surviving a soft reset: enable, init-on-enable, four power-mode bits
  localparam logic [CTRL_W-1:0] KEEP_MASK = CTRL_W'(32'h003C_0003);

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_FAST = 2'd2,
    SRC_SLOW = 2'd3
  } tickSrcT;

  typedef struct packed {
    logic             softRst;
    logic             setCount;
    logic [CNT_W-1:0] setValue;
    logic             clrPresc;
    logic             clrFlag;
  } tdtCmdT;
endpackage

// File: rtl/tdt_ticksel.sv
module tdt_ticksel
  import tdt_pkg::*;
(
  input  tickSrcT src,
  input  logic    tickMain,
  input  logic    tickFast,
  input  logic    tickSlow,
  output logic    tickSel
);
  always_comb begin
    unique case (src)
      SRC_MAIN: tickSel = tickMain;
      SRC_FAST: tickSel = tickFast;
      SRC_SLOW: tickSel = tickSlow;
      default:  tickSel = 1'b0;
    endcase
  end
endmodule

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              flagIn,
  output logic              cfgEn,
  output logic              cfgRld,
  output logic              cfgOcie,
  output logic [PSC_W-1:0]  cfgPsc,
  output tickSrcT           cfgSrc,
  output logic [CNT_W-1:0]  loadQ,
  output logic [CNT_W-1:0]  cmpQ,
  output tdtCmdT            cmd
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_LOAD = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_CMP  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  ALL_ONES = '1;
  localparam logic [CTRL_W-1:0] SWR_CLR  = ~(CTRL_W'(1) << B_SWR);

  logic [CTRL_W-1:0] ctrlQ;
  logic wrCtrl, wrStat, wrLoad, wrCmp, rdAcc;
  logic softRst, enRise;

  assign wrCtrl = busSel && busWr && (busAddr == OFF_CTRL);
  assign wrStat = busSel && busWr && (busAddr == OFF_STAT);
  assign wrLoad = busSel && busWr && (busAddr == OFF_LOAD);
  assign wrCmp  = busSel && busWr && (busAddr == OFF_CMP);
  assign rdAcc  = busSel && !busWr;

  assign softRst = wrCtrl && busWdata[B_SWR];
  assign enRise  = wrCtrl && !softRst && busWdata[B_EN] && !ctrlQ[B_EN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      loadQ <= ALL_ONES;
      cmpQ  <= '0;
    end else begin
      if (softRst) begin
        ctrlQ <= busWdata[CTRL_W-1:0] & KEEP_MASK;
        loadQ <= ALL_ONES;
        cmpQ  <= '0;
      end else begin
        if (wrCtrl) ctrlQ <= busWdata[CTRL_W-1:0] & SWR_CLR;
        if (wrLoad) loadQ <= busWdata;
        if (wrCmp)  cmpQ  <= busWdata;
      end
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.softRst  = softRst;
    cmd.clrPresc = enRise;
    cmd.clrFlag  = wrStat && busWdata[0];
    if (enRise && busWdata[B_INITEN]) begin
      cmd.setCount = 1'b1;
      cmd.setValue = busWdata[B_RLD] ? loadQ : ALL_ONES;
    end else if (wrLoad && ctrlQ[B_OVW]) begin
      cmd.setCount = 1'b1;
      cmd.setValue = busWdata;
    end
  end

  assign cfgEn   = ctrlQ[B_EN];
  assign cfgRld  = ctrlQ[B_RLD];
  assign cfgOcie = ctrlQ[B_OCIE];
  assign cfgPsc  = ctrlQ[B_PSC +: PSC_W];
  assign cfgSrc  = tickSrcT'(ctrlQ[B_SRC +: SRC_W]);

  always_comb begin
    busRdata = '0;
    if (rdAcc) begin
      unique case (busAddr)
        OFF_CTRL: busRdata = {{(CNT_W-CTRL_W){1'b0}}, ctrlQ};
        OFF_STAT: busRdata = {{(CNT_W-1){1'b0}}, flagIn};
        OFF_LOAD: busRdata = loadQ;
        OFF_CMP:  busRdata = cmpQ;
        OFF_CNT:  busRdata = countIn;
        default:  busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tdt_datapath.sv
module tdt_datapath
  import tdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tdtCmdT           cmd,
  input  logic             cfgEn,
  input  logic             cfgRld,
  input  logic [PSC_W-1:0] cfgPsc,
  input  logic             tickSel,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] countQ,
  output logic             flagQ,
  output logic             tickFire
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [PSC_W-1:0] pscQ;
  logic             pscWrap;
  logic             tickGate;
  logic [CNT_W-1:0] nextCount;
  logic             cmpHit;

  assign tickGate  = cfgEn && tickSel;
  assign pscWrap   = (pscQ >= cfgPsc);
  assign tickFire  = tickGate && pscWrap;
  assign nextCount = (countQ == '0) ? (cfgRld ? loadVal : ALL_ONES) : countQ - 1'b1;
  assign cmpHit    = tickFire && !cmd.setCount && (nextCount == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscQ   <= '0;
      countQ <= '0;
      flagQ  <= 1'b0;
    end else if (cmd.softRst) begin
      pscQ   <= '0;
      countQ <= '0;
      flagQ  <= 1'b0;
    end else begin
      if (cmd.clrPresc)  pscQ <= '0;
      else if (tickGate) pscQ <= pscWrap ? '0 : pscQ + 1'b1;

      if (cmd.setCount)  countQ <= cmd.setValue;
      else if (tickFire) countQ <= nextCount;

      if (cmpHit)           flagQ <= 1'b1;
      else if (cmd.clrFlag) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/tdt_top.sv
module tdt_top
  import tdt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              tickMain,
  input  logic              tickFast,
  input  logic              tickSlow,
  output logic              irq
);
  tdtCmdT           cmd;
  logic             ctrlEn, ctrlRld, ctrlOcie;
  logic [PSC_W-1:0] ctrlPsc;
  tickSrcT          ctrlSrc;
  logic [CNT_W-1:0] loadQ, cmpQ, countQ;
  logic             flagQ, tickSel, tickFire;

  tdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .countIn(countQ), .flagIn(flagQ),
    .cfgEn(ctrlEn), .cfgRld(ctrlRld), .cfgOcie(ctrlOcie),
    .cfgPsc(ctrlPsc), .cfgSrc(ctrlSrc),
    .loadQ(loadQ), .cmpQ(cmpQ), .cmd(cmd)
  );

  tdt_ticksel u_tsel (
    .src(ctrlSrc), .tickMain(tickMain), .tickFast(tickFast),
    .tickSlow(tickSlow), .tickSel(tickSel)
  );

  tdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .cfgEn(ctrlEn), .cfgRld(ctrlRld), .cfgPsc(ctrlPsc),
    .tickSel(tickSel), .loadVal(loadQ), .cmpVal(cmpQ),
    .countQ(countQ), .flagQ(flagQ), .tickFire(tickFire)
  );

  assign irq = flagQ && ctrlOcie && ctrlEn;
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              ctrlEn,
  input logic              tickFire,
  input logic [31:0]       countQ,
  input logic [31:0]       loadQ,
  input logic              flagQ
);
  logic anyWr;
  assign anyWr = busSel && busWr;

  p_map_hole_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr > ADDR_W'(4)) |-> busRdata == 32'h0);

  p_ctrl_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == ADDR_W'(0)) |-> (busRdata[31:26] == 6'h0 && !busRdata[16]));

  p_step_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tickFire && countQ != 32'h0 && !anyWr) |=> countQ == $past(countQ) - 32'h1);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(anyWr && ((busAddr == ADDR_W'(1) && busWdata[0]) ||
                          (busAddr == ADDR_W'(0) && busWdata[16])))) |=> flagQ);

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && busAddr == ADDR_W'(1) && busWdata[0] && !tickFire) |=> !flagQ);

  p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && busAddr == ADDR_W'(0) && busWdata[16]) |=> (countQ == 32'h0 && !flagQ && loadQ == 32'hFFFF_FFFF));

  p_frozen_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlEn && !anyWr) |=> $stable(countQ));
endmodule

bind tdt_top tdt_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .ctrlEn(ctrlEn), .tickFire(tickFire), .countQ(countQ),
  .loadQ(loadQ), .flagQ(flagQ)
);

// File: tb/tb_tdt_top.sv
`timescale 1ns/1ps
module tb_tdt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickMain = 1'b0, tickFast = 1'b0, tickSlow = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } expItemT;
  expItemT sbq[$];

  always #2 clk = ~clk;

  tdt_top dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickMain(tickMain), .tickFast(tickFast), .tickSlow(tickSlow), .irq(irq)
  );

  // monitor: compare every queued expectation 1 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        expItemT it;
        logic [31:0] act;
        it = sbq.pop_front();
        act = it.isIrq ? {31'b0, irq} : busRdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic expectRead(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    sbq.push_back('{isIrq: 1'b0, exp: e, tag: tag});
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic expectIrq(input logic e, input string tag);
    @(negedge clk);
    sbq.push_back('{isIrq: 1'b1, exp: {31'b0, e}, tag: tag});
    @(negedge clk);
  endtask

  task automatic setTick(input int which, input logic v);
    if (which == 0) tickMain = v;
    else if (which == 1) tickFast = v;
    else tickSlow = v;
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      setTick(which, 1'b1);
      @(negedge clk);
      setTick(which, 1'b0);
    end
  endtask

  task automatic writeWithTick(input logic [2:0] a, input logic [31:0] d, input int which);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    setTick(which, 1'b1);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    setTick(which, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3 reset values
    expectRead(3'd0, 32'h0, "R3 ctrl");
    expectRead(3'd1, 32'h0, "R3 status");
    expectRead(3'd2, 32'hFFFF_FFFF, "R3 load");
    expectRead(3'd3, 32'h0, "R3 compare");
    expectRead(3'd4, 32'h0, "R3 counter");
    expectIrq(1'b0, "R3 irq");

    // R2 upper bits dropped
    busWrite(3'd0, 32'hFC00_0008);
    expectRead(3'd0, 32'h0000_0008, "R2 ctrl width");

    // R1 map and holes
    busWrite(3'd2, 32'd5);
    busWrite(3'd5, 32'h1234_5678);
    busWrite(3'd4, 32'hAAAA_AAAA);
    expectRead(3'd5, 32'h0, "R1 hole 5");
    expectRead(3'd6, 32'h0, "R1 hole 6");
    expectRead(3'd7, 32'h0, "R1 hole 7");
    expectRead(3'd2, 32'd5, "R1 load intact");
    expectRead(3'd4, 32'h0, "R1 counter not writable");

    // R7 enable edge in reload mode loads from load register
    busWrite(3'd0, 32'h0100_000B);
    expectRead(3'd4, 32'd5, "R7 init from load");

    // R4 source main, other sources ignored
    pulse(0, 1);
    pulse(2, 1);
    pulse(1, 1);
    expectRead(3'd4, 32'd4, "R4 only main counts");

    // R6 reload at zero; R9 flag at compare 0; R11 irq gated by ocie
    pulse(0, 4);
    expectRead(3'd4, 32'd0, "R6 reached zero");
    expectRead(3'd1, 32'd1, "R9 flag at compare 0");
    expectIrq(1'b0, "R11 irq needs ocie");
    pulse(0, 1);
    expectRead(3'd4, 32'd5, "R6 reload");

    // R10 status clear
    busWrite(3'd1, 32'h0);
    expectRead(3'd1, 32'd1, "R10 zero write no effect");
    busWrite(3'd1, 32'h1);
    expectRead(3'd1, 32'd0, "R10 clear");

    // R9 compare hit, R11 irq
    busWrite(3'd3, 32'd3);
    busWrite(3'd0, 32'h0100_000F);
    pulse(0, 1);
    expectRead(3'd1, 32'd0, "R9 no hit at 4");
    pulse(0, 1);
    expectRead(3'd1, 32'd1, "R9 hit at 3");
    expectIrq(1'b1, "R11 irq high");
    busWrite(3'd0, 32'h0100_000B);
    expectIrq(1'b0, "R11 ocie off");
    expectRead(3'd1, 32'd1, "R9 flag sticky");
    busWrite(3'd0, 32'h0100_000F);
    expectIrq(1'b1, "R11 ocie back on");
    busWrite(3'd1, 32'h1);
    expectIrq(1'b0, "R10 irq drops after clear");

    // R9 set wins over clear: counter 3 -> 2,1,0,5,4 then 3 with clear
    pulse(0, 5);
    expectRead(3'd4, 32'd4, "R6 cycle position");
    writeWithTick(3'd1, 32'h1, 0);
    expectRead(3'd1, 32'd1, "R9 set beats clear");
    busWrite(3'd1, 32'h1);

    // R8 load without overwrite used at next reload
    busWrite(3'd2, 32'd9);
    expectRead(3'd4, 32'd3, "R8 counter untouched");
    pulse(0, 3);
    expectRead(3'd4, 32'd0, "R8 before reload");
    pulse(0, 1);
    expectRead(3'd4, 32'd9, "R8 new load at reload");

    // R8 overwrite
    busWrite(3'd0, 32'h0102_000F);
    busWrite(3'd2, 32'd7);
    expectRead(3'd4, 32'd7, "R8 overwrite");

    // R5 prescaler divide by 3
    busWrite(3'd0, 32'h0102_002F);
    pulse(0, 2);
    expectRead(3'd4, 32'd7, "R5 two ticks no count");
    pulse(0, 1);
    expectRead(3'd4, 32'd6, "R5 third tick counts");

    // R4 source off, slow, fast
    busWrite(3'd0, 32'h0002_002F);
    pulse(0, 3);
    expectRead(3'd4, 32'd6, "R4 source off frozen");
    busWrite(3'd0, 32'h0302_002F);
    pulse(2, 3);
    expectRead(3'd4, 32'd5, "R4 slow source");
    pulse(0, 3);
    expectRead(3'd4, 32'd5, "R4 main ignored in slow");
    busWrite(3'd0, 32'h0202_002F);
    pulse(1, 3);
    expectRead(3'd4, 32'd4, "R4 fast source");

    // R13 disabled counter frozen
    busWrite(3'd0, 32'h0102_0006);
    busWrite(3'd2, 32'd1);
    expectRead(3'd4, 32'd1, "R8 overwrite while disabled");
    pulse(0, 2);
    expectRead(3'd4, 32'd1, "R13 frozen when disabled");

    // R7 free-run init and R6 wrap
    busWrite(3'd0, 32'h0102_0007);
    expectRead(3'd4, 32'hFFFF_FFFF, "R7 init all ones");
    pulse(0, 1);
    expectRead(3'd4, 32'hFFFF_FFFE, "R6 free-run decrement");
    busWrite(3'd2, 32'd0);
    pulse(0, 1);
    expectRead(3'd4, 32'hFFFF_FFFF, "R6 free-run wrap");

    // R7 enable without init keeps counter
    busWrite(3'd0, 32'h0102_0004);
    busWrite(3'd2, 32'd2);
    busWrite(3'd0, 32'h0102_0005);
    expectRead(3'd4, 32'd2, "R7 no init keeps counter");

    // R12 soft reset
    busWrite(3'd3, 32'd2);
    busWrite(3'd0, 32'h013D_000F);
    expectRead(3'd0, 32'h003C_0003, "R12 kept ctrl bits, R2 bit 16 reads 0");
    expectRead(3'd1, 32'h0, "R12 status");
    expectRead(3'd2, 32'hFFFF_FFFF, "R12 load");
    expectRead(3'd3, 32'h0, "R12 compare");
    expectRead(3'd4, 32'h0, "R12 counter");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule